// File: doc/BRIEF.md
# Correctable Error Threshold Counter

This block is the thresholding register for one machine-check error-reporting bank. It holds a 64-bit register split into two 32-bit words. The upper word carries a 12-bit corrected-error counter, an overflow flag, a count enable, a 2-bit interrupt-type selector, a 4-bit interrupt vector table offset, a lock bit and read-only status bits. The lower word is read-only and reports whether further threshold registers exist.

Software picks a threshold of L errors (1 to 0xFFF) by writing 0xFFF − L into the count field and clearing the overflow flag in the same write. Every corrected-error pulse from the bank then advances the counter while counting is enabled. The pulse that brings the count to 0xFFF sets the overflow flag. If the type field selects local-interrupt delivery, the block also raises a one-cycle interrupt request that carries the stored offset. The number of errors seen so far is the count field minus (0xFFF − L).

Top module: `err_thresh_bank`

## Requirements
- R1: After reset the upper word reads with bit 31 (valid) = 1, bit 30 (counter present) = 1, bit 28 (interrupt capable) = the INT_CAP parameter, and every other bit 0: lock, offset, count enable, type, overflow and count are all cleared. The lower word reads BLK_PTR in bits [31:24] and zero in bits [23:0].
- R2: A write to the upper word (wr_hi = 1) while unlocked loads these fields, and a read returns them: count [11:0], overflow bit 16, type [18:17], count enable bit 19, offset [23:20] and lock bit 29. Bits 31, 30 and 28 are read-only. A write to the lower word changes nothing.
- R3: An err_pulse high at a clock edge adds 1 to the count only when count enable is 1. With count enable 0 the count does not change.
- R4: The count never wraps. A pulse when the count is 0xFFF leaves it at 0xFFF, and overflow stays 1.
- R5: After the count is preset to 0xFFF − L with overflow cleared, overflow stays 0 for the first L − 1 pulses and becomes 1 on pulse number L, the pulse that brings the count to 0xFFF.
- R6: When a pulse sets overflow from 0 to 1 and type is 01, irq_req is high for exactly one cycle, in the cycle after that pulse's clock edge, with irq_offset equal to the stored offset. With type 00, 10 or 11 there is no request.
- R7: Once the lock bit is 1, writes to the upper word are ignored and error pulses do not count. The lock stays set until reset. Reads still return the current contents.
- R8: If an unlocked upper-word write and an error pulse land on the same clock edge, the write sets the fields and that pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_hi | input | 1 | Write word select: 1 for the upper word, 0 for the lower word |
| wr_data | input | 32 | Write data |
| rd_hi | input | 1 | Read word select: 1 for the upper word, 0 for the lower word |
| rd_data | output | 32 | Read data for the selected word (combinational) |
| err_pulse | input | 1 | Corrected-error event, one count per high clock edge |
| irq_req | output | 1 | One-cycle interrupt request on threshold overflow |
| irq_offset | output | 4 | Interrupt vector table offset sent with irq_req, zero otherwise |

## Verification
A software write to the upper word and an error pulse can fall on the same clock edge, and both would change the count field. The bench drives wr_en and err_pulse high in the same cycle and then reads the count back. It expects exactly the written value, with no extra increment. A second, lone pulse must then add exactly one, which shows that the counter itself is still live and that only the colliding pulse was dropped.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int CNT_W  = 12;
  localparam int OFS_W  = 4;
  localparam int TYPE_W = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // upper-word field positions (decoded by software)
  localparam int POS_OVF   = 16;
  localparam int POS_TYPE  = 17;
  localparam int POS_CEN   = 19;
  localparam int POS_OFS   = 20;
  localparam int POS_LOCK  = 29;

  typedef enum logic [TYPE_W-1:0] {
    ITYPE_NONE  = 2'b00,
    ITYPE_LOCAL = 2'b01,
    ITYPE_RSV2  = 2'b10,
    ITYPE_RSV3  = 2'b11
  } itype_e;
endpackage

// File: rtl/thr_rst_sync.sv
module thr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/thr_count_unit.sv
module thr_count_unit import thr_pkg::*; (
  input  logic [CNT_W-1:0] count_q,
  input  logic             ovf_q,
  input  logic             cen_q,
  input  logic             lock_q,
  input  logic             err_pulse,
  output logic [CNT_W-1:0] count_nxt,
  output logic             ovf_nxt,
  output logic             ovf_rise
);
  logic step;
  logic at_max;
  logic [CNT_W-1:0] inc_val;

  always_comb begin
    step      = err_pulse & cen_q & ~lock_q;
    at_max    = (count_q == CNT_MAX);
    inc_val   = at_max ? count_q : count_q + 1'b1;
    count_nxt = step ? inc_val : count_q;
    ovf_nxt   = ovf_q | (step & (inc_val == CNT_MAX));
    ovf_rise  = ovf_nxt & ~ovf_q;
  end
endmodule

// File: rtl/thr_irq_gen.sv
module thr_irq_gen import thr_pkg::*; (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic             fire,
  input  logic [TYPE_W-1:0] itype,
  input  logic [OFS_W-1:0] ofs,
  output logic             irq_req,
  output logic [OFS_W-1:0] irq_offset
);
  logic             req_d, req_q;
  logic [OFS_W-1:0] ofs_d, ofs_q;

  always_comb begin
    req_d = fire & (itype == ITYPE_LOCAL);
    ofs_d = req_d ? ofs : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_q <= 1'b0;
      ofs_q <= '0;
    end else begin
      req_q <= req_d;
      ofs_q <= ofs_d;
    end
  end

  assign irq_req    = req_q;
  assign irq_offset = ofs_q;

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_req |=> !irq_req);
endmodule

// File: rtl/err_thresh_bank.sv
module err_thresh_bank import thr_pkg::*; #(
  parameter bit         INT_CAP = 1'b1,
  parameter logic [7:0] BLK_PTR = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_hi,
  input  logic [31:0] wr_data,
  input  logic        rd_hi,
  output logic [31:0] rd_data,
  input  logic        err_pulse,
  output logic        irq_req,
  output logic [3:0]  irq_offset
);
  logic rst_sync_n;

  logic [CNT_W-1:0]  count_q, count_d, count_nxt;
  logic              ovf_q, ovf_d, ovf_nxt, ovf_rise;
  logic              cen_q, cen_d;
  logic [TYPE_W-1:0] itype_q, itype_d;
  logic [OFS_W-1:0]  ofs_q, ofs_d;
  logic              lock_q, lock_d;
  logic              write_hit;
  logic [31:0]       up_word, lo_word;
  logic              unused_wr_bits;

  thr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  thr_count_unit u_cnt (
    .count_q(count_q), .ovf_q(ovf_q), .cen_q(cen_q), .lock_q(lock_q),
    .err_pulse(err_pulse), .count_nxt(count_nxt), .ovf_nxt(ovf_nxt),
    .ovf_rise(ovf_rise)
  );

  assign write_hit = wr_en & wr_hi & ~lock_q;

  // next-state: a software write overrides the counter path
  always_comb begin
    count_d = count_nxt;
    ovf_d   = ovf_nxt;
    cen_d   = cen_q;
    itype_d = itype_q;
    ofs_d   = ofs_q;
    lock_d  = lock_q;
    if (write_hit) begin
      count_d = wr_data[CNT_W-1:0];
      ovf_d   = wr_data[POS_OVF];
      cen_d   = wr_data[POS_CEN];
      itype_d = INT_CAP ? wr_data[POS_TYPE +: TYPE_W] : ITYPE_NONE;
      ofs_d   = wr_data[POS_OFS +: OFS_W];
      lock_d  = wr_data[POS_LOCK];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
      cen_q   <= 1'b0;
      itype_q <= ITYPE_NONE;
      ofs_q   <= '0;
      lock_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      ovf_q   <= ovf_d;
      cen_q   <= cen_d;
      itype_q <= itype_d;
      ofs_q   <= ofs_d;
      lock_q  <= lock_d;
    end
  end

  thr_irq_gen u_irq (
    .clk(clk), .rst_sync_n(rst_sync_n),
    .fire(ovf_rise & ~write_hit), .itype(itype_q), .ofs(ofs_q),
    .irq_req(irq_req), .irq_offset(irq_offset)
  );

  assign up_word = {1'b1, 1'b1, lock_q, INT_CAP, 4'b0000, ofs_q, cen_q,
                    itype_q, ovf_q, 4'b0000, count_q};
  assign lo_word = {BLK_PTR, 24'h000000};
  assign rd_data = rd_hi ? up_word : lo_word;

  assign unused_wr_bits = ^{wr_data[31:30], wr_data[28:24], wr_data[15:12]};

  assert_irq_type_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_req |-> (itype_q == ITYPE_LOCAL) && ovf_q && (irq_offset == ofs_q));

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovf_q && count_q == CNT_MAX && !(wr_en && wr_hi)) |=> (ovf_q && count_q == CNT_MAX));

  assert_cen_gate_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cen_q && !(wr_en && wr_hi)) |=> $stable(count_q));

  assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lock_q |=> (lock_q && $stable(count_q) && $stable(itype_q) && $stable(ofs_q)));
endmodule

// File: tb/err_thresh_bank_test.sv
module err_thresh_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_hi, rd_hi, err_pulse;
  logic [31:0] wr_data, rd_data;
  logic        irq_req;
  logic [3:0]  irq_offset;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  err_thresh_bank #(.INT_CAP(1'b1), .BLK_PTR(8'h3C)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .rd_hi(rd_hi), .rd_data(rd_data), .err_pulse(err_pulse),
    .irq_req(irq_req), .irq_offset(irq_offset)
  );

  always @(posedge clk) if (irq_req) irq_seen++;

  function automatic logic [31:0] up(input bit lk, input logic [3:0] ofs, input bit cen,
                                     input logic [1:0] ty, input bit ovf, input logic [11:0] cnt);
    return {1'b1, 1'b1, lk, 1'b1, 4'b0, ofs, cen, ty, ovf, 4'b0, cnt};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input bit hi, output logic [31:0] v);
    rd_hi = hi;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input bit hi, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); err_pulse = 1'b1;
    end
    @(negedge clk); err_pulse = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(1'b1, v); chk(v, up(0, 0, 0, 2'b00, 0, 12'h000), "R1 upper after reset");
    rd(1'b0, v); chk(v, 32'h3C00_0000, "R1 lower after reset");
  endtask

  task automatic t_rw();
    logic [31:0] v;
    wr(1'b1, up(0, 4'h9, 0, 2'b10, 1, 12'h123) & 32'h2FFF_FFFF);
    rd(1'b1, v); chk(v, up(0, 4'h9, 0, 2'b10, 1, 12'h123), "R2 upper readback");
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, v); chk(v, 32'h3C00_0000, "R2 lower write ignored");
    rd(1'b1, v); chk(v, up(0, 4'h9, 0, 2'b10, 1, 12'h123), "R2 upper untouched by lower write");
  endtask

  task automatic t_count_enable();
    logic [31:0] v;
    wr(1'b1, up(0, 0, 0, 2'b00, 0, 12'd10));
    pulses(3);
    rd(1'b1, v); chk({20'b0, v[11:0]}, 32'd10, "R3 no count when disabled");
    wr(1'b1, up(0, 0, 1, 2'b00, 0, 12'd10));
    pulses(3);
    rd(1'b1, v); chk({20'b0, v[11:0]}, 32'd13, "R3 count when enabled");
  endtask

  task automatic t_threshold();
    logic [31:0] v;
    int base;
    base = irq_seen;
    wr(1'b1, up(0, 4'h2, 1, 2'b00, 1, 12'h000));
    wr(1'b1, up(0, 4'h2, 1, 2'b00, 0, 12'hFFF - 12'd4));
    pulses(3);
    rd(1'b1, v); chk({31'b0, v[16]}, 32'd0, "R5 no overflow before limit");
    chk({20'b0, v[11:0]}, 32'hFFE, "R5 count before limit");
    pulses(1);
    rd(1'b1, v); chk({31'b0, v[16]}, 32'd1, "R5 overflow at limit");
    chk(irq_seen - base, 0, "R6 no request with type 00");
    pulses(5);
    rd(1'b1, v); chk({19'b0, v[16], v[11:0]}, 32'h1FFF, "R4 saturated, overflow held");
  endtask

  task automatic t_irq();
    logic [31:0] v;
    int base;
    base = irq_seen;
    wr(1'b1, up(0, 4'h5, 1, 2'b01, 0, 12'hFFE));
    @(negedge clk); err_pulse = 1'b1;
    @(negedge clk); err_pulse = 1'b0;
    chk({27'b0, irq_req, irq_offset}, 32'h15, "R6 request with offset");
    @(negedge clk);
    chk({31'b0, irq_req}, 32'd0, "R6 request lasts one cycle");
    chk(irq_seen - base, 1, "R6 exactly one request");
    base = irq_seen;
    wr(1'b1, up(0, 4'h5, 1, 2'b10, 0, 12'hFFE));
    pulses(2);
    rd(1'b1, v); chk({31'b0, v[16]}, 32'd1, "R6 overflow with type 10");
    chk(irq_seen - base, 0, "R6 no request with type 10");
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(1'b1, up(1, 4'h3, 1, 2'b01, 0, 12'h100));
    rd(1'b1, v); chk(v, up(1, 4'h3, 1, 2'b01, 0, 12'h100), "R7 lock set");
    wr(1'b1, up(0, 4'hA, 0, 2'b00, 1, 12'h777));
    rd(1'b1, v); chk(v, up(1, 4'h3, 1, 2'b01, 0, 12'h100), "R7 write ignored when locked");
    pulses(2);
    rd(1'b1, v); chk({20'b0, v[11:0]}, 32'h100, "R7 no count when locked");
    do_reset();
    rd(1'b1, v); chk(v, up(0, 0, 0, 2'b00, 0, 12'h000), "R1 R7 reset clears lock");
  endtask

  task automatic t_collision();
    logic [31:0] v;
    wr(1'b1, up(0, 0, 1, 2'b00, 0, 12'h050));
    @(negedge clk);
    wr_en = 1'b1; wr_hi = 1'b1; wr_data = up(0, 0, 1, 2'b00, 0, 12'h200); err_pulse = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; err_pulse = 1'b0;
    rd(1'b1, v); chk({20'b0, v[11:0]}, 32'h200, "R8 write wins over pulse");
    pulses(1);
    rd(1'b1, v); chk({20'b0, v[11:0]}, 32'h201, "R8 later pulse counts");
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_hi = 1'b0; wr_data = '0; rd_hi = 1'b1; err_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_rw();
    t_count_enable();
    t_threshold();
    t_irq();
    t_lock();
    t_collision();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule